// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive monitor for the command bus of a single-rank SDR SDRAM with four banks. It watches the select, row-strobe, column-strobe and write-enable lines, the bank address and the auto-precharge/all-banks address bit on every clock. From them it works out which command was issued and which bank it addresses. Each bank has its own set of down-counters, and two counters are shared by all banks. Together they enforce the row and column spacing rules of the memory: minimum activate spacing, activate-to-column delay, precharge time, minimum and maximum row-open time, row cycle time, write recovery, and the combined write-recovery-plus-precharge delay that follows a write with auto-precharge.

Every limit is given as a time in picoseconds together with the clock period. At elaboration each limit becomes a clock count by dividing and rounding up. The package holds constants for three speed grades, and the defaults use the middle one. The first broken rule sets a sticky flag and latches a 4-bit code and the offending bank. These hold until a synchronous reset. The checker is meant to be bound beside a memory controller in simulation or left in an FPGA build as a run-time watchdog.

Top module: `sdr_timing_monitor`

## Requirements
- R1: Each time limit becomes a clock count equal to ceil(limit_ps / CLK_PS). With the defaults (8000 ps clock) this gives an activate-to-precharge minimum of 6 clocks (42 ns) and a row cycle of 8 clocks (60 ns); a limit of 80 ns gives 10 clocks.
- R2: Commands are decoded with select low and {row, column, write} strobes, all active low: 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no-op. With select high the cycle is ignored. The auto-precharge/all-banks bit set on a precharge applies it to every bank.
- R3: An activate fewer than ceil(tRRD) clocks after any earlier activate latches code 1 for the bank being activated.
- R4: A read or write fewer than ceil(tRCD) clocks after that bank's activate latches code 2.
- R5: An activate fewer than ceil(tRP) clocks after that bank's explicit precharge latches code 3.
- R6: A precharge of an open bank fewer than ceil(tRAS) clocks after its activate latches code 4.
- R7: An activate fewer than ceil(tRC) clocks after that bank's previous activate latches code 5.
- R8: A bank that stays open for more than ceil(tRAS max) clocks latches code 6. A precharge exactly that many clocks after the activate is legal.
- R9: A precharge fewer than BURST_LEN-1+WR_CLK clocks after a write to that bank latches code 7. After a write with auto-precharge, an activate to that bank fewer than BURST_LEN-1+WR_CLK+ceil(tRP) clocks later latches code 8.
- R10: After a read with auto-precharge, an activate to that bank fewer than BURST_LEN+ceil(tRP) clocks later latches code 9.
- R11: A write while read data is still due latches code 10. Read data lasts CAS_LAT+BURST_LEN clocks from the read. A burst stop, or a precharge that covers the reading bank, cuts this to CAS_LAT clocks from the cutting command, so 2 trailing words at latency 3 and 1 at latency 2 are still expected.
- R12: An activate to an already open bank latches code 11. A read or write to a closed bank latches code 12.
- R13: After reset the flag is 0 and the code and bank are 0. The flag rises on the clock edge that samples the first offending command. The lowest code wins, and within it the lowest bank. Flag, code and bank then hold until reset.
- R14: Legal traffic never raises the flag, including column commands on consecutive cycles and activates to different banks exactly ceil(tRRD) apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, same as the memory clock |
| rst | input | 1 | Synchronous active-high reset, clears all state and the flag |
| cmd_sel_n | input | 1 | Command select, active low |
| cmd_row_n | input | 1 | Row strobe, active low |
| cmd_col_n | input | 1 | Column strobe, active low |
| cmd_wr_n | input | 1 | Write enable, active low |
| cmd_bank | input | BANK_BITS | Bank address |
| cmd_apflag | input | 1 | Auto-precharge on read/write, all banks on precharge |
| viol | output | 1 | Sticky violation flag |
| viol_code | output | 4 | Code of the first rule broken |
| viol_bank | output | BANK_BITS | Bank of the first rule broken |

## Verification
The assertions assume that reset is held for at least one edge before traffic starts. They also assume the bus never holds unknown values outside reset, because every edge after reset is treated as carrying a decoded command. The bench drives a no-op with select low on every cycle that has no scheduled command, changes inputs only on the falling edge, and applies a fresh reset before each scenario, so counters from one scenario never leak into the next. Each violating sequence breaks exactly one rule by one clock: the other gaps in it are set at or above their limits, so the latched code depends on no priority choice.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

  localparam int NCODE = 16;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_BST, C_OTHER
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_RRD       = 4'd1,
    E_RCD       = 4'd2,
    E_RP        = 4'd3,
    E_RAS       = 4'd4,
    E_RC        = 4'd5,
    E_RASMAX    = 4'd6,
    E_WREC      = 4'd7,
    E_DAL       = 4'd8,
    E_RDAP      = 4'd9,
    E_TURN      = 4'd10,
    E_ACTOPEN   = 4'd11,
    E_COLCLOSED = 4'd12
  } err_e;

  // Speed grade constants, picoseconds
  localparam int FAST_RRD_PS = 10000;
  localparam int FAST_RCD_PS = 15000;
  localparam int FAST_RP_PS  = 15000;
  localparam int FAST_RAS_PS = 37500;
  localparam int FAST_RC_PS  = 55000;

  localparam int MID_RRD_PS  = 12000;
  localparam int MID_RCD_PS  = 18000;
  localparam int MID_RP_PS   = 18000;
  localparam int MID_RAS_PS  = 42000;
  localparam int MID_RC_PS   = 60000;

  localparam int SLOW_RRD_PS = 15000;
  localparam int SLOW_RCD_PS = 20000;
  localparam int SLOW_RP_PS  = 20000;
  localparam int SLOW_RAS_PS = 45000;
  localparam int SLOW_RC_PS  = 65000;

  localparam int RAS_MAX_PS  = 100_000_000;

  function automatic int ps_to_clk(input int t_ps, input int per_ps);
    return (t_ps + per_ps - 1) / per_ps;
  endfunction

  // A gap of g clocks means the counter is loaded with g-1 after the opening command
  function automatic int gap_load(input int g);
    return (g > 1) ? g - 1 : 0;
  endfunction

endpackage

// File: rtl/sdr_mon_decode.sv
module sdr_mon_decode
  import sdr_mon_pkg::*;
(
  input  logic cmd_sel_n,
  input  logic cmd_row_n,
  input  logic cmd_col_n,
  input  logic cmd_wr_n,
  output cmd_e cmd
);

  always_comb begin
    if (cmd_sel_n) begin
      cmd = C_NOP;
    end else begin
      case ({cmd_row_n, cmd_col_n, cmd_wr_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b110:  cmd = C_BST;
        3'b111:  cmd = C_NOP;
        default: cmd = C_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sdr_mon_bank.sv
module sdr_mon_bank
  import sdr_mon_pkg::*;
#(
  parameter int SW        = 5,
  parameter int LW        = 14,
  parameter int RCD_LD    = 2,
  parameter int RP_LD     = 2,
  parameter int RAS_LD    = 5,
  parameter int RC_LD     = 7,
  parameter int RASMAX_LD = 12500,
  parameter int WREC_LD   = 4,
  parameter int DAL_LD    = 7,
  parameter int RDAP_LD   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             apflag,
  output logic [NCODE-1:0] hit
);

  logic          open;
  logic [SW-1:0] rcd_cnt, rp_cnt, ras_cnt, rc_cnt, wrec_cnt;
  logic [LW-1:0] life_cnt;
  err_e          act_why;

  logic is_act, is_col, is_pre;
  assign is_act = sel && (cmd == C_ACT);
  assign is_col = sel && ((cmd == C_RD) || (cmd == C_WR));
  assign is_pre = (cmd == C_PRE) && (sel || apflag);

  always_comb begin
    hit = '0;
    if (is_act) begin
      if (open) begin
        hit[E_ACTOPEN] = 1'b1;
      end else begin
        if (rp_cnt != '0) hit[act_why] = 1'b1;
        if (rc_cnt != '0) hit[E_RC]    = 1'b1;
      end
    end
    if (is_col) begin
      if (!open)              hit[E_COLCLOSED] = 1'b1;
      else if (rcd_cnt != '0) hit[E_RCD]       = 1'b1;
    end
    if (is_pre && open) begin
      if (ras_cnt != '0)  hit[E_RAS]  = 1'b1;
      if (wrec_cnt != '0) hit[E_WREC] = 1'b1;
    end
    if (open && (life_cnt == '0)) hit[E_RASMAX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open     <= 1'b0;
      rcd_cnt  <= '0;
      rp_cnt   <= '0;
      ras_cnt  <= '0;
      rc_cnt   <= '0;
      wrec_cnt <= '0;
      life_cnt <= '0;
      act_why  <= E_RP;
    end else begin
      if (rcd_cnt  != '0) rcd_cnt  <= rcd_cnt  - 1'b1;
      if (rp_cnt   != '0) rp_cnt   <= rp_cnt   - 1'b1;
      if (ras_cnt  != '0) ras_cnt  <= ras_cnt  - 1'b1;
      if (rc_cnt   != '0) rc_cnt   <= rc_cnt   - 1'b1;
      if (wrec_cnt != '0) wrec_cnt <= wrec_cnt - 1'b1;
      if (life_cnt != '0) life_cnt <= life_cnt - 1'b1;
      if (is_act) begin
        open     <= 1'b1;
        rcd_cnt  <= SW'(RCD_LD);
        ras_cnt  <= SW'(RAS_LD);
        rc_cnt   <= SW'(RC_LD);
        wrec_cnt <= '0;
        life_cnt <= LW'(RASMAX_LD);
      end else if (is_col && open) begin
        if (cmd == C_WR) begin
          if (apflag) begin
            open    <= 1'b0;
            rp_cnt  <= SW'(DAL_LD);
            act_why <= E_DAL;
          end else begin
            wrec_cnt <= SW'(WREC_LD);
          end
        end else if (apflag) begin
          open    <= 1'b0;
          rp_cnt  <= SW'(RDAP_LD);
          act_why <= E_RDAP;
        end
      end else if (is_pre && open) begin
        open    <= 1'b0;
        rp_cnt  <= SW'(RP_LD);
        act_why <= E_RP;
      end
    end
  end

  a_r12_act_opens: assert property (@(posedge clk) disable iff (rst)
    is_act |=> open);

  a_r5_pre_closes: assert property (@(posedge clk) disable iff (rst)
    (is_pre && open && !is_act) |=> !open);

  a_r4_rcd_bound: assert property (@(posedge clk) disable iff (rst)
    rcd_cnt <= SW'(RCD_LD));

  a_r8_life_reload: assert property (@(posedge clk) disable iff (rst)
    is_act |=> (life_cnt == LW'(RASMAX_LD)));

endmodule

// File: rtl/sdr_mon_bus.sv
module sdr_mon_bus
  import sdr_mon_pkg::*;
#(
  parameter int BW      = 2,
  parameter int SW      = 5,
  parameter int RRD_LD  = 1,
  parameter int TURN_LD = 6,
  parameter int CUT_LD  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic [BW-1:0] bank,
  input  logic          apflag,
  output logic          hit_rrd,
  output logic          hit_turn
);

  logic [SW-1:0] rrd_cnt, rdq_cnt, rdq_dec;
  logic [BW-1:0] rd_bank;
  logic          cut;

  assign hit_rrd  = (cmd == C_ACT) && (rrd_cnt != '0);
  assign hit_turn = (cmd == C_WR)  && (rdq_cnt != '0);
  assign rdq_dec  = (rdq_cnt != '0) ? rdq_cnt - 1'b1 : '0;
  assign cut      = (cmd == C_BST) ||
                    ((cmd == C_PRE) && (apflag || (bank == rd_bank)));

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_cnt <= '0;
      rdq_cnt <= '0;
      rd_bank <= '0;
    end else begin
      if (cmd == C_ACT)          rrd_cnt <= SW'(RRD_LD);
      else if (rrd_cnt != '0)    rrd_cnt <= rrd_cnt - 1'b1;
      if (cmd == C_RD) begin
        rdq_cnt <= SW'(TURN_LD);
        rd_bank <= bank;
      end else if (cut) begin
        rdq_cnt <= (rdq_dec < SW'(CUT_LD)) ? rdq_dec : SW'(CUT_LD);
      end else begin
        rdq_cnt <= rdq_dec;
      end
    end
  end

  a_r11_queue_bound: assert property (@(posedge clk) disable iff (rst)
    rdq_cnt <= SW'(TURN_LD));

  a_r11_cut_shrinks: assert property (@(posedge clk) disable iff (rst)
    (cut && cmd != C_RD) |=> (rdq_cnt <= SW'(CUT_LD)));

  a_r3_rrd_armed: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT) |=> (rrd_cnt == SW'(RRD_LD)));

endmodule

// File: rtl/sdr_mon_report.sv
module sdr_mon_report
  import sdr_mon_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NB-1:0][NCODE-1:0] hits,
  output logic                     viol,
  output logic [3:0]               viol_code,
  output logic [BW-1:0]            viol_bank
);

  logic          any;
  logic [3:0]    pick_code;
  logic [BW-1:0] pick_bank;

  always_comb begin
    any       = |hits;
    pick_code = '0;
    pick_bank = '0;
    for (int c = NCODE - 1; c >= 0; c--) begin
      for (int b = NB - 1; b >= 0; b--) begin
        if (hits[b][c]) begin
          pick_code = 4'(c);
          pick_bank = BW'(b);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_code <= '0;
      viol_bank <= '0;
    end else if (!viol && any) begin
      viol      <= 1'b1;
      viol_code <= pick_code;
      viol_bank <= pick_bank;
    end
  end

  a_r13_sticky: assert property (@(posedge clk) disable iff (rst)
    viol |=> (viol && $stable(viol_code) && $stable(viol_bank)));

  a_r13_code_nonzero: assert property (@(posedge clk) disable iff (rst)
    viol |-> (viol_code != 4'd0));

  a_r13_capture: assert property (@(posedge clk) disable iff (rst)
    (any && !viol) |=> viol);

  a_r13_quiet: assert property (@(posedge clk) disable iff (rst)
    (!any && !viol) |=> !viol);

endmodule

// File: rtl/sdr_timing_monitor.sv
module sdr_timing_monitor
  import sdr_mon_pkg::*;
#(
  parameter int BANK_BITS   = 2,
  parameter int CLK_PS      = 8000,
  parameter int CAS_LAT     = 3,
  parameter int BURST_LEN   = 4,
  parameter int WR_CLK      = 2,
  parameter int T_RRD_PS    = MID_RRD_PS,
  parameter int T_RCD_PS    = MID_RCD_PS,
  parameter int T_RP_PS     = MID_RP_PS,
  parameter int T_RAS_PS    = MID_RAS_PS,
  parameter int T_RC_PS     = MID_RC_PS,
  parameter int T_RASMAX_PS = RAS_MAX_PS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_sel_n,
  input  logic                 cmd_row_n,
  input  logic                 cmd_col_n,
  input  logic                 cmd_wr_n,
  input  logic [BANK_BITS-1:0] cmd_bank,
  input  logic                 cmd_apflag,
  output logic                 viol,
  output logic [3:0]           viol_code,
  output logic [BANK_BITS-1:0] viol_bank
);

  localparam int NB       = 1 << BANK_BITS;
  localparam int RRD_C    = ps_to_clk(T_RRD_PS, CLK_PS);
  localparam int RCD_C    = ps_to_clk(T_RCD_PS, CLK_PS);
  localparam int RP_C     = ps_to_clk(T_RP_PS, CLK_PS);
  localparam int RAS_C    = ps_to_clk(T_RAS_PS, CLK_PS);
  localparam int RC_C     = ps_to_clk(T_RC_PS, CLK_PS);
  localparam int RASMAX_C = ps_to_clk(T_RASMAX_PS, CLK_PS);

  localparam int RRD_LD   = gap_load(RRD_C);
  localparam int RCD_LD   = gap_load(RCD_C);
  localparam int RP_LD    = gap_load(RP_C);
  localparam int RAS_LD   = gap_load(RAS_C);
  localparam int RC_LD    = gap_load(RC_C);
  localparam int WREC_LD  = gap_load(BURST_LEN - 1 + WR_CLK);
  localparam int DAL_LD   = gap_load(BURST_LEN - 1 + WR_CLK + RP_C);
  localparam int RDAP_LD  = gap_load(BURST_LEN + RP_C);
  localparam int TURN_LD  = gap_load(CAS_LAT + BURST_LEN);
  localparam int CUT_LD   = gap_load(CAS_LAT);

  localparam int SHORT_SUM = RRD_LD + RCD_LD + RP_LD + RAS_LD + RC_LD +
                             WREC_LD + DAL_LD + RDAP_LD + TURN_LD;
  localparam int SW = $clog2(SHORT_SUM + 2);
  localparam int LW = $clog2(RASMAX_C + 2);

  cmd_e cmd;
  logic hit_rrd, hit_turn;
  logic [NCODE-1:0]         bus_hit;
  logic [NB-1:0][NCODE-1:0] bank_hit;
  logic [NB-1:0][NCODE-1:0] all_hit;

  sdr_mon_decode u_decode (
    .cmd_sel_n (cmd_sel_n),
    .cmd_row_n (cmd_row_n),
    .cmd_col_n (cmd_col_n),
    .cmd_wr_n  (cmd_wr_n),
    .cmd       (cmd)
  );

  sdr_mon_bus #(
    .BW(BANK_BITS), .SW(SW), .RRD_LD(RRD_LD),
    .TURN_LD(TURN_LD), .CUT_LD(CUT_LD)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .bank     (cmd_bank),
    .apflag   (cmd_apflag),
    .hit_rrd  (hit_rrd),
    .hit_turn (hit_turn)
  );

  always_comb begin
    bus_hit         = '0;
    bus_hit[E_RRD]  = hit_rrd;
    bus_hit[E_TURN] = hit_turn;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdr_mon_bank #(
      .SW(SW), .LW(LW), .RCD_LD(RCD_LD), .RP_LD(RP_LD), .RAS_LD(RAS_LD),
      .RC_LD(RC_LD), .RASMAX_LD(RASMAX_C), .WREC_LD(WREC_LD),
      .DAL_LD(DAL_LD), .RDAP_LD(RDAP_LD)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .cmd    (cmd),
      .sel    (cmd_bank == BANK_BITS'(b)),
      .apflag (cmd_apflag),
      .hit    (bank_hit[b])
    );
    assign all_hit[b] = bank_hit[b] |
                        ((cmd_bank == BANK_BITS'(b)) ? bus_hit : '0);
  end

  sdr_mon_report #(.NB(NB), .BW(BANK_BITS)) u_report (
    .clk       (clk),
    .rst       (rst),
    .hits      (all_hit),
    .viol      (viol),
    .viol_code (viol_code),
    .viol_bank (viol_bank)
  );

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd_sel_n && !viol) |=> !viol);

endmodule

// File: tb/sdr_timing_monitor_bench.sv
`timescale 1ns/1ps
module sdr_timing_monitor_bench;

  localparam logic [2:0] K_ACT = 3'b011;
  localparam logic [2:0] K_RD  = 3'b101;
  localparam logic [2:0] K_WR  = 3'b100;
  localparam logic [2:0] K_PRE = 3'b010;
  localparam logic [2:0] K_BST = 3'b110;
  localparam logic [2:0] K_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b0, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1;
  logic [1:0] bank = 2'd0;
  logic apf = 1'b0;
  logic       m_viol, a_viol;
  logic [3:0] m_code, a_code;
  logic [1:0] m_bank, a_bank;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  sdr_timing_monitor u_sdr_timing_monitor (
    .clk(clk), .rst(rst), .cmd_sel_n(sel_n), .cmd_row_n(row_n),
    .cmd_col_n(col_n), .cmd_wr_n(wr_n), .cmd_bank(bank), .cmd_apflag(apf),
    .viol(m_viol), .viol_code(m_code), .viol_bank(m_bank)
  );

  sdr_timing_monitor #(.CAS_LAT(2), .T_RC_PS(80000)) u_alt (
    .clk(clk), .rst(rst), .cmd_sel_n(sel_n), .cmd_row_n(row_n),
    .cmd_col_n(col_n), .cmd_wr_n(wr_n), .cmd_bank(bank), .cmd_apflag(apf),
    .viol(a_viol), .viol_code(a_code), .viol_bank(a_bank)
  );

  task automatic issue(input logic [2:0] k, input logic [1:0] b, input logic a);
    @(negedge clk);
    sel_n = 1'b0;
    {row_n, col_n, wr_n} = k;
    bank = b;
    apf  = a;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(K_NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {row_n, col_n, wr_n} = K_NOP;
    sel_n = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Samples on the falling edge after the last command's rising edge
  task automatic expect_mon(input string req, input bit alt,
                            input logic ev, input logic [3:0] ec,
                            input logic [1:0] eb);
    logic v; logic [3:0] c; logic [1:0] b;
    issue(K_NOP, 2'd0, 1'b0);
    v = alt ? a_viol : m_viol;
    c = alt ? a_code : m_code;
    b = alt ? a_bank : m_bank;
    vectors++;
    if (v !== ev || c !== ec || b !== eb) begin
      errors++;
      $display("FAIL %s (%s): got viol=%0b code=%0d bank=%0d, expected viol=%0b code=%0d bank=%0d",
               req, alt ? "alt" : "main", v, c, b, ev, ec, eb);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_mon("R13 reset state", 0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_legal();
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(1);
    issue(K_ACT, 2'd1, 0);
    issue(K_WR, 2'd0, 0);
    issue(K_WR, 2'd0, 0);
    issue(K_RD, 2'd1, 0);
    issue(K_RD, 2'd1, 0); nops(2);
    issue(K_PRE, 2'd0, 0); nops(2);
    issue(K_ACT, 2'd0, 0);
    issue(K_PRE, 2'd1, 0);
    expect_mon("R14 legal traffic", 0, 1'b0, 4'd0, 2'd0);
    expect_mon("R14 legal traffic", 1, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_deselect();
    do_reset();
    issue(K_ACT, 2'd0, 0);
    @(negedge clk); sel_n = 1'b1; {row_n, col_n, wr_n} = K_ACT; bank = 2'd1;
    nops(1);
    issue(K_ACT, 2'd2, 0);
    expect_mon("R2 deselected cycle ignored", 0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_rrd();
    do_reset();
    issue(K_ACT, 2'd0, 0);
    issue(K_ACT, 2'd1, 0);
    expect_mon("R3 activate spacing", 0, 1'b1, 4'd1, 2'd1);
  endtask

  task automatic t_rcd();
    do_reset();
    issue(K_ACT, 2'd2, 0); nops(1);
    issue(K_RD, 2'd2, 0);
    expect_mon("R4 activate to column", 0, 1'b1, 4'd2, 2'd2);
  endtask

  task automatic t_rp();
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(5);
    issue(K_PRE, 2'd0, 0); nops(1);
    issue(K_ACT, 2'd0, 0);
    expect_mon("R5 precharge to activate", 0, 1'b1, 4'd3, 2'd0);
  endtask

  task automatic t_ras();
    do_reset();
    issue(K_ACT, 2'd3, 0); nops(4);
    issue(K_PRE, 2'd3, 0);
    expect_mon("R6 R1 row open 5 of 6 clocks", 0, 1'b1, 4'd4, 2'd3);
  endtask

  task automatic t_rc();
    do_reset();
    issue(K_ACT, 2'd1, 0); nops(5);
    issue(K_PRE, 2'd1, 0); nops(2);
    issue(K_ACT, 2'd1, 0);
    expect_mon("R7 R1 row cycle 9 of 8 ok", 0, 1'b0, 4'd0, 2'd0);
    expect_mon("R7 R1 row cycle 9 of 10", 1, 1'b1, 4'd5, 2'd1);
  endtask

  task automatic t_rasmax();
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(12499);
    issue(K_PRE, 2'd0, 0);
    expect_mon("R8 open exactly at limit", 0, 1'b0, 4'd0, 2'd0);
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(12502);
    expect_mon("R8 open past limit", 0, 1'b1, 4'd6, 2'd0);
  endtask

  task automatic t_write_rec();
    do_reset();
    issue(K_ACT, 2'd1, 0); nops(2);
    issue(K_WR, 2'd1, 0); nops(3);
    issue(K_PRE, 2'd1, 0);
    expect_mon("R9 write recovery", 0, 1'b1, 4'd7, 2'd1);
  endtask

  task automatic t_dal();
    do_reset();
    issue(K_ACT, 2'd2, 0); nops(2);
    issue(K_WR, 2'd2, 1); nops(6);
    issue(K_ACT, 2'd2, 0);
    expect_mon("R9 auto-precharge write to activate", 0, 1'b1, 4'd8, 2'd2);
    do_reset();
    issue(K_ACT, 2'd2, 0); nops(2);
    issue(K_WR, 2'd2, 1); nops(7);
    issue(K_ACT, 2'd2, 0);
    expect_mon("R9 auto-precharge write at limit", 0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_rdap();
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(2);
    issue(K_RD, 2'd0, 1); nops(5);
    issue(K_ACT, 2'd0, 0);
    expect_mon("R10 auto-precharge read to activate", 0, 1'b1, 4'd9, 2'd0);
  endtask

  task automatic t_turn();
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(1);
    issue(K_ACT, 2'd1, 0);
    issue(K_RD, 2'd0, 0); nops(1);
    issue(K_BST, 2'd0, 0); nops(1);
    issue(K_WR, 2'd1, 0);
    expect_mon("R11 trailing words at latency 3", 0, 1'b1, 4'd10, 2'd1);
    expect_mon("R11 trailing word at latency 2", 1, 1'b0, 4'd0, 2'd0);
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(1);
    issue(K_ACT, 2'd1, 0);
    issue(K_RD, 2'd0, 0); nops(1);
    issue(K_BST, 2'd0, 0); nops(2);
    issue(K_WR, 2'd1, 0);
    expect_mon("R11 write after trailing words", 0, 1'b0, 4'd0, 2'd0);
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(1);
    issue(K_ACT, 2'd1, 0);
    issue(K_RD, 2'd0, 0); nops(5);
    issue(K_WR, 2'd1, 0);
    expect_mon("R11 write into full read burst", 0, 1'b1, 4'd10, 2'd1);
  endtask

  task automatic t_state();
    do_reset();
    issue(K_RD, 2'd3, 0);
    expect_mon("R12 column to closed bank", 0, 1'b1, 4'd12, 2'd3);
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(7);
    issue(K_ACT, 2'd0, 0);
    expect_mon("R12 activate open bank", 0, 1'b1, 4'd11, 2'd0);
  endtask

  task automatic t_pre_all();
    do_reset();
    issue(K_ACT, 2'd0, 0); nops(1);
    issue(K_ACT, 2'd2, 0); nops(4);
    issue(K_PRE, 2'd3, 1);
    expect_mon("R2 all-bank precharge checks bank 2", 0, 1'b1, 4'd4, 2'd2);
  endtask

  task automatic t_sticky();
    do_reset();
    issue(K_ACT, 2'd0, 0);
    issue(K_ACT, 2'd1, 0); nops(2);
    issue(K_RD, 2'd3, 0);
    expect_mon("R13 first violation held", 0, 1'b1, 4'd1, 2'd1);
    do_reset();
    expect_mon("R13 cleared by reset", 0, 1'b0, 4'd0, 2'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_legal();
    t_deselect();
    t_rrd();
    t_rcd();
    t_rp();
    t_ras();
    t_rc();
    t_write_rec();
    t_dal();
    t_rdap();
    t_turn();
    t_state();
    t_pre_all();
    t_sticky();
    t_rasmax();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule